// File: doc/BRIEF.md
# Shared-Bus Register Access Slave

This block sits between an external 8-bit microcontroller-style bus and an on-chip register file. On that bus the low address byte and the data use the same bidirectional lines. The high address byte has its own input bus. The master raises a latch-enable strobe while it presents the address. After the strobe falls, the shared lines are free for one data transfer, framed by an active-low read strobe or an active-low write strobe.

The slave stores the full address when the latch strobe falls and keeps it stable until the next address phase. It turns a write strobe into a single-cycle write-enable toward the register file, with the sampled data. It turns a read strobe into a single-cycle read-enable, for registers that clear when read. While the read strobe is low, it puts the register file's combinational read data onto the shared lines. Wait states and burst transfers are not handled here.

Top module: `muxbus_slave`

## Requirements
- R1: During and after a synchronous active-high reset, with no bus activity, `reg_we` and `reg_re` are 0, and `reg_addr` and `reg_wdata` are all zeros.
- R2: At every clock edge with `ale` high, the value `{bus_hi, bus_ad}` is taken in, with `bus_hi` in the upper bits. After the first edge at which `ale` is sampled low, `reg_addr` shows the value taken at the last edge where `ale` was high.
- R3: `reg_addr` changes only after a high-to-low transition of `ale`. Data on `bus_ad`, changes on `bus_hi`, and read or write strobes while `ale` is low leave it unchanged.
- R4: While `rd_n` is low, the slave drives `bus_ad` combinationally with `reg_rdata`. While `rd_n` is high it releases `bus_ad`, so a value driven by the master appears unaltered.
- R5: Each read strobe gives exactly one `reg_re` pulse, one clock long. The pulse comes in the cycle after the first edge at which `rd_n` is sampled low, whatever the length of the strobe.
- R6: When `wr_n` returns high, `reg_we` is high for exactly one cycle. The pulse starts after the first edge at which `wr_n` is sampled high following a low sample. `reg_wdata` then holds the `bus_ad` value from the last edge at which `wr_n` was low. Bus values after the strobe ends are ignored.
- R7: A read strobe never raises `reg_we` and never changes `reg_wdata`. A write strobe never raises `reg_re`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_ad | inout | DATA_W | Shared lines: low address byte during the latch phase, data afterwards |
| bus_hi | input | HADDR_W | Upper address bits, valid while `ale` is high |
| ale | input | 1 | Address latch enable, active high |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| reg_addr | output | DATA_W+HADDR_W | Held register address |
| reg_wdata | output | DATA_W | Write data toward the register file |
| reg_we | output | 1 | One-cycle write enable |
| reg_re | output | 1 | One-cycle read enable |
| reg_rdata | input | DATA_W | Combinational read data from the register file |

## Verification
The bench builds the slave with a 4-bit shared bus and a 3-bit high address bus. This makes all 128 addresses reachable in one sweep. Each address gets a full address phase, a write of an address-derived value, and a read whose strobe length cycles through one to three clocks. The register file model in the bench returns the XOR of both address parts with 5, so every read value can be predicted from the address that was issued. Bus release is checked at every address by driving two complementary patterns from the master side.

// File: rtl/ms_pkg.sv
package ms_pkg;
  // Polarity of the transition an edge detector reports.
  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_kind_e;
endpackage

// File: rtl/ms_edge.sv
// Synchronous edge detector: compares the current sample with the one
// taken at the previous clock edge.
module ms_edge
  import ms_pkg::*;
#(
  parameter edge_kind_e KIND = EDGE_FALL,
  parameter logic       IDLE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic sig,
  output logic pulse
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= IDLE;
    else     prev_q <= sig;
  end

  generate
    if (KIND == EDGE_RISE) begin : g_rise
      assign pulse = ~prev_q & sig;
    end else begin : g_fall
      assign pulse = prev_q & ~sig;
    end
  endgenerate
endmodule

// File: rtl/ms_addr_latch.sv
// Tracks the address while the latch enable is high and commits it on the
// enable's falling edge.
module ms_addr_latch #(
  parameter int DATA_W  = 8,
  parameter int HADDR_W = 8,
  localparam int ADDR_W = DATA_W + HADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ale,
  input  logic              ale_fall,
  input  logic [DATA_W-1:0] lo_in,
  input  logic [HADDR_W-1:0] hi_in,
  output logic [ADDR_W-1:0] addr_q
);
  logic [ADDR_W-1:0] shadow_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      addr_q   <= '0;
    end else begin
      if (ale)      shadow_q <= {hi_in, lo_in};
      if (ale_fall) addr_q   <= shadow_q;
    end
  end
endmodule

// File: rtl/ms_write_path.sv
// Samples bus data while the write strobe is low; issues the write on release.
module ms_write_path #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_low,
  input  logic              wr_end,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] wdata_q,
  output logic              we_q
);
  logic [DATA_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
    end else begin
      if (wr_low) hold_q <= data_in;
      we_q <= wr_end;
      if (wr_end) wdata_q <= hold_q;
    end
  end
endmodule

// File: rtl/ms_read_path.sv
// Registers a single read-enable pulse per read strobe.
module ms_read_path (
  input  logic clk,
  input  logic rst,
  input  logic rd_start,
  output logic re_q
);
  always_ff @(posedge clk) begin
    if (rst) re_q <= 1'b0;
    else     re_q <= rd_start;
  end
endmodule

// File: rtl/muxbus_slave.sv
module muxbus_slave
  import ms_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int HADDR_W = 8,
  localparam int ADDR_W = DATA_W + HADDR_W
) (
  input  logic               clk,
  input  logic               rst,
  inout  wire  [DATA_W-1:0]  bus_ad,
  input  logic [HADDR_W-1:0] bus_hi,
  input  logic               ale,
  input  logic               rd_n,
  input  logic               wr_n,
  output logic [ADDR_W-1:0]  reg_addr,
  output logic [DATA_W-1:0]  reg_wdata,
  output logic               reg_we,
  output logic               reg_re,
  input  logic [DATA_W-1:0]  reg_rdata
);
  logic ale_fall;
  logic rd_start;
  logic wr_end;

  // The shared lines are driven only during the read strobe.
  assign bus_ad = rd_n ? {DATA_W{1'bz}} : reg_rdata;

  ms_edge #(.KIND(EDGE_FALL), .IDLE(1'b0)) u_ale_edge (
    .clk(clk), .rst(rst), .sig(ale), .pulse(ale_fall)
  );

  ms_edge #(.KIND(EDGE_FALL), .IDLE(1'b1)) u_rd_edge (
    .clk(clk), .rst(rst), .sig(rd_n), .pulse(rd_start)
  );

  ms_edge #(.KIND(EDGE_RISE), .IDLE(1'b1)) u_wr_edge (
    .clk(clk), .rst(rst), .sig(wr_n), .pulse(wr_end)
  );

  ms_addr_latch #(.DATA_W(DATA_W), .HADDR_W(HADDR_W)) u_addr (
    .clk(clk), .rst(rst), .ale(ale), .ale_fall(ale_fall),
    .lo_in(bus_ad), .hi_in(bus_hi), .addr_q(reg_addr)
  );

  ms_write_path #(.DATA_W(DATA_W)) u_wr (
    .clk(clk), .rst(rst), .wr_low(~wr_n), .wr_end(wr_end),
    .data_in(bus_ad), .wdata_q(reg_wdata), .we_q(reg_we)
  );

  ms_read_path u_rd (
    .clk(clk), .rst(rst), .rd_start(rd_start), .re_q(reg_re)
  );
endmodule

// File: rtl/ms_checker.sv
module ms_checker #(
  parameter int DATA_W  = 8,
  parameter int HADDR_W = 8,
  localparam int ADDR_W = DATA_W + HADDR_W
) (
  input logic              clk,
  input logic              rst,
  input logic              ale,
  input logic              rd_n,
  input logic              wr_n,
  input logic [DATA_W-1:0] bus_ad,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_we,
  input logic              reg_re,
  input logic [DATA_W-1:0] reg_rdata
);
  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(reg_addr)) |-> ($past(ale, 2) && !$past(ale)));

  assert_drive_read_R4: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> (bus_ad == reg_rdata));

  assert_re_single_R5: assert property (@(posedge clk) disable iff (rst)
    reg_re |=> !reg_re);

  assert_re_cause_R5: assert property (@(posedge clk) disable iff (rst)
    (reg_re && !$past(rst)) |-> !$past(rd_n));

  assert_we_single_R6: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we);

  assert_we_cause_R7: assert property (@(posedge clk) disable iff (rst)
    (reg_we && !$past(rst)) |-> ($past(wr_n) && !$past(wr_n, 2)));
endmodule

bind muxbus_slave ms_checker #(.DATA_W(DATA_W), .HADDR_W(HADDR_W)) u_chk (
  .clk(clk), .rst(rst), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
  .bus_ad(bus_ad), .reg_addr(reg_addr), .reg_we(reg_we),
  .reg_re(reg_re), .reg_rdata(reg_rdata)
);

// File: tb/muxbus_slave_bench.sv
module muxbus_slave_bench;
  localparam int DW = 4;
  localparam int HW = 3;
  localparam int AW = DW + HW;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ale = 1'b0;
  logic rd_n = 1'b1;
  logic wr_n = 1'b1;
  logic [HW-1:0] bus_hi = '0;
  logic m_drv = 1'b0;
  logic [DW-1:0] m_val = '0;
  wire  [DW-1:0] ad_w;
  logic [AW-1:0] reg_addr;
  logic [DW-1:0] reg_wdata;
  logic reg_we;
  logic reg_re;
  logic [DW-1:0] rf_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  assign ad_w = m_drv ? m_val : {DW{1'bz}};
  // Register-file model: low part XOR high part XOR 5.
  assign rf_rdata = reg_addr[DW-1:0] ^ DW'(reg_addr[AW-1:DW]) ^ DW'(5);

  always #(CLK_PERIOD / 2) clk = ~clk;

  muxbus_slave #(.DATA_W(DW), .HADDR_W(HW)) u_muxbus_slave (
    .clk(clk), .rst(rst), .bus_ad(ad_w), .bus_hi(bus_hi), .ale(ale),
    .rd_n(rd_n), .wr_n(wr_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(rf_rdata)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic addr_phase(input logic [DW-1:0] lo, input logic [HW-1:0] hi);
    @(negedge clk);
    ale = 1'b1; m_drv = 1'b1; m_val = lo; bus_hi = hi;
    @(negedge clk);
    ale = 1'b0; m_val = ~lo; bus_hi = ~hi;   // ignored after the latch phase
    @(negedge clk);
    m_drv = 1'b0;
    check("R2 reg_addr after ale fall", int'(reg_addr), int'({hi, lo}));
  endtask

  task automatic write_op(input logic [DW-1:0] d);
    @(negedge clk);
    wr_n = 1'b0; m_drv = 1'b1; m_val = d;
    @(negedge clk);
    wr_n = 1'b1; m_val = ~d;                 // must not be sampled
    check("R6 reg_we low before release seen", int'(reg_we), 0);
    @(negedge clk);
    m_drv = 1'b0;
    check("R6 reg_we pulse", int'(reg_we), 1);
    check("R6 reg_wdata", int'(reg_wdata), int'(d));
    check("R7 no reg_re on write", int'(reg_re), 0);
    @(negedge clk);
    check("R6 reg_we one cycle", int'(reg_we), 0);
  endtask

  task automatic read_op(input logic [DW-1:0] exp, input int len,
                         input logic [DW-1:0] wd);
    int re_cnt = 0;
    int we_cnt = 0;
    @(negedge clk);
    rd_n = 1'b0; m_drv = 1'b0;
    #1;
    check("R4 bus driven with read data", int'(ad_w), int'(exp));
    for (int k = 0; k < len + 2; k++) begin
      @(negedge clk);
      re_cnt += int'(reg_re);
      we_cnt += int'(reg_we);
      if (k == len - 1) rd_n = 1'b1;
    end
    check("R5 one reg_re per strobe", re_cnt, 1);
    check("R7 no reg_we on read", we_cnt, 0);
    check("R7 reg_wdata kept over read", int'(reg_wdata), int'(wd));
    m_drv = 1'b1; m_val = 4'h5;
    #1;
    check("R4 bus released pattern a", int'(ad_w), 5);
    m_val = 4'hA;
    #1;
    check("R4 bus released pattern b", int'(ad_w), 10);
    m_drv = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog (all R) actual=timeout expected=completion");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1 reg_we in reset", int'(reg_we), 0);
    check("R1 reg_re in reset", int'(reg_re), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 reg_addr after reset", int'(reg_addr), 0);
    check("R1 reg_wdata after reset", int'(reg_wdata), 0);
    check("R1 reg_we idle", int'(reg_we), 0);
    check("R1 reg_re idle", int'(reg_re), 0);

    for (int a = 0; a < (1 << AW); a++) begin
      logic [DW-1:0] lo;
      logic [HW-1:0] hi;
      logic [DW-1:0] d;
      logic [DW-1:0] exp;
      lo  = DW'(a);
      hi  = HW'(a >> DW);
      d   = DW'(a * 3 + 7);
      exp = lo ^ DW'(hi) ^ DW'(5);
      addr_phase(lo, hi);
      write_op(d);
      check("R3 reg_addr held after write", int'(reg_addr), a);
      // Changing the high bus while ale is low must not move the address.
      bus_hi = ~hi;
      read_op(exp, (a % 3) + 1, d);
      check("R3 reg_addr held after read", int'(reg_addr), a);
    end
    summary();
  end
endmodule